// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a management-bus master that sends exactly one serial management frame to an external PHY for each command that the host issues. A single 32-bit command word holds the frame type and all of its fields. The frame type is set by the start-code field: code 01 selects the short-address framing and code 00 selects the extended framing. A separate 16-bit write-data register supplies the payload for write frames. The 16 bits that a read frame returns appear on a read-data port.

The host loads the write data first, if the frame needs any. It then writes the command word with the go bit set. From that point it polls the go bit, which the controller clears once the frame, including one trailing idle clock, has finished. The management clock is generated internally only while a frame is running. Its half period is programmable in system clocks, so software can keep it at or below 2.5 MHz.

The sequencer moves through six states:
- **IDLE**: goes to PREAMBLE when a command with go set arrives.
- **PREAMBLE**: sends 32 ones, then goes to HEADER.
- **HEADER**: sends 14 bits, then goes to TURN.
- **TURN**: covers 2 bit times, then goes to DATA.
- **DATA**: covers 16 bit times, then goes to GAP.
- **GAP**: one released clock period, then goes back to IDLE.

Each transition happens on a falling edge of the management clock.

Top module: `mdio_master`

## Requirements
- R1: After reset, `mdc` is low, `mdio_oe` is low, `cmd_rdata` is all zero and `rd_data` is zero.
- R2: The command word layout is: bit 30 go, bits [29:28] start code, [27:26] opcode, [25:21] PHY address, [20:16] device/register number, [15:0] register address. A command written with go=1 while idle reads back unchanged, with bit 30 set, one cycle later, and it starts a frame.
- R3: Every frame begins with 32 consecutive ones driven on MDIO.
- R4: After the preamble, the controller drives start code, opcode, PHY address and bits [20:16], each MSB first. With start code 01, bits [20:16] are the register number and bits [15:0] have no effect on the line.
- R5: When opcode bit 1 is 0, the controller drives turnaround 1 then 0, and then 16 payload bits MSB first. The payload is bits [15:0] of the command when start code=00 and opcode=00 (address frame). In all other such frames it is the write-data register.
- R6: When opcode bit 1 is 1 (opcode 10 with either start code, or 11 with start code 00), MDIO is released for both turnaround bits and all 16 data bits. The 16 bits sampled on MDC rising edges, MSB first, appear on `rd_data` when go clears.
- R7: MDC half period is `mdc_half`+1 system clocks, and MDIO output and enable never change while MDC is high.
- R8: After the last data bit, exactly one further MDC period passes with MDIO released. Then go clears, and MDC stays low while idle.
- R9: A command written while go is set does not alter the command readback and does not start another frame.
- R10: `rd_data` keeps its previous value across frames whose opcode bit 1 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mdc_half | input | DIV_W | MDC half period minus one, in system clocks |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word value |
| cmd_rdata | output | 32 | Command word readback; bit 30 is go/busy |
| wd_we | input | 1 | Write-data register strobe |
| wd_wdata | input | 16 | Write-data value |
| rd_data | output | 16 | Data returned by the last read frame |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (high = master drives) |
| mdio_i | input | 1 | MDIO line as seen at the pin |

## Verification
The assertions assume that `mdc_half` is held constant while a frame runs. They also assume that the PHY changes the line only while MDC is low, so that a sample taken at a rising edge sees a settled bit. The stimulus changes `mdc_half` only between frames, with go clear. The PHY model drives read data only on falling MDC edges, and only for the 16 data bit times of read frames. Command strobes during a frame are issued on purpose, to exercise the rule that such commands are ignored.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PRE_BITS  = 32;
    localparam int HDR_BITS  = 14;
    localparam int TA_BITS   = 2;
    localparam int DATA_BITS = 16;
    localparam int WORD_BITS = HDR_BITS + TA_BITS + DATA_BITS;
    localparam int CNT_W     = $clog2(PRE_BITS);

    localparam logic [1:0] START_EXT   = 2'b00;
    localparam logic [1:0] OPC_ADDRESS = 2'b00;
    localparam logic [1:0] TA_DRIVEN   = 2'b10;

    typedef struct packed {
        logic        spare;
        logic        go;
        logic [1:0]  start;
        logic [1:0]  opc;
        logic [4:0]  phy;
        logic [4:0]  dev;
        logic [15:0] regad;
    } mgmt_cmd_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PREAMBLE,
        S_HEADER,
        S_TURN,
        S_DATA,
        S_GAP
    } frame_state_e;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             mdc,
    output logic             rise_ev,
    output logic             fall_ev
);

    logic [DIV_W-1:0] cnt_q;
    logic             tick;

    assign tick    = run && (cnt_q >= half);
    assign rise_ev = tick && !mdc;
    assign fall_ev = tick && mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            mdc   <= !mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R8: clock parks low whenever no frame runs
    assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);

endmodule

// File: rtl/mdio_rxshift.sv
module mdio_rxshift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
        end else if (clr) begin
            data <= '0;
        end else if (en) begin
            data <= {data[W-2:0], din};
        end
    end

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] mdc_half,
    input  logic             cmd_we,
    input  logic [31:0]      cmd_wdata,
    output logic [31:0]      cmd_rdata,
    input  logic             wd_we,
    input  logic [15:0]      wd_wdata,
    output logic [15:0]      rd_data,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);

    mgmt_cmd_t              cmd_q, cmd_in;
    logic [DATA_BITS-1:0]   wd_q, rd_q, rx_word;
    frame_state_e           state_q, state_d;
    logic [CNT_W-1:0]       cnt_q, cnt_d;
    logic [WORD_BITS-1:0]   sr_q, sr_d;
    logic                   rise_ev, fall_ev, run, start, is_rd, frame_done;

    assign cmd_in     = mgmt_cmd_t'(cmd_wdata);
    assign start      = (state_q == S_IDLE) && cmd_we && cmd_in.go;
    assign is_rd      = cmd_q.opc[1];
    assign run        = (state_q != S_IDLE);
    assign frame_done = (state_q == S_GAP) && fall_ev;
    assign cmd_rdata  = cmd_q;
    assign rd_data    = rd_q;

    function automatic logic [WORD_BITS-1:0] frame_word(input mgmt_cmd_t c,
                                                        input logic [DATA_BITS-1:0] wd);
        logic [DATA_BITS-1:0] payload;
        payload = (c.start == START_EXT && c.opc == OPC_ADDRESS) ? c.regad : wd;
        return {c.start, c.opc, c.phy, c.dev, TA_DRIVEN, payload};
    endfunction

    mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .half    (mdc_half),
        .mdc     (mdc),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev)
    );

    mdio_rxshift #(.W(DATA_BITS)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .en    (rise_ev && state_q == S_DATA && is_rd),
        .din   (mdio_i),
        .data  (rx_word)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        sr_d    = sr_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    state_d = S_PREAMBLE;
                    cnt_d   = '0;
                    sr_d    = frame_word(cmd_in, wd_q);
                end
            end
            S_PREAMBLE: begin
                if (fall_ev) begin
                    if (cnt_q == CNT_W'(PRE_BITS - 1)) begin
                        state_d = S_HEADER;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            S_HEADER: begin
                if (fall_ev) begin
                    sr_d = {sr_q[WORD_BITS-2:0], 1'b0};
                    if (cnt_q == CNT_W'(HDR_BITS - 1)) begin
                        state_d = S_TURN;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            S_TURN: begin
                if (fall_ev) begin
                    sr_d = {sr_q[WORD_BITS-2:0], 1'b0};
                    if (cnt_q == CNT_W'(TA_BITS - 1)) begin
                        state_d = S_DATA;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            S_DATA: begin
                if (fall_ev) begin
                    sr_d = {sr_q[WORD_BITS-2:0], 1'b0};
                    if (cnt_q == CNT_W'(DATA_BITS - 1)) begin
                        state_d = S_GAP;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            S_GAP: begin
                if (fall_ev) begin
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            sr_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sr_q    <= sr_d;
        end
    end

    // host-visible registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
            wd_q  <= '0;
            rd_q  <= '0;
        end else begin
            if (state_q == S_IDLE && cmd_we) begin
                cmd_q <= cmd_in;
            end else if (frame_done) begin
                cmd_q.go <= 1'b0;
            end
            if (wd_we) begin
                wd_q <= wd_wdata;
            end
            if (frame_done && is_rd) begin
                rd_q <= rx_word;
            end
        end
    end

    // line outputs
    always_comb begin
        mdio_oe = 1'b0;
        mdio_o  = 1'b0;
        unique case (state_q)
            S_IDLE, S_GAP: begin
                mdio_oe = 1'b0;
            end
            S_PREAMBLE: begin
                mdio_oe = 1'b1;
                mdio_o  = 1'b1;
            end
            S_HEADER: begin
                mdio_oe = 1'b1;
                mdio_o  = sr_q[WORD_BITS-1];
            end
            S_TURN, S_DATA: begin
                mdio_oe = !is_rd;
                mdio_o  = is_rd ? 1'b0 : sr_q[WORD_BITS-1];
            end
            default: mdio_oe = 1'b0;
        endcase
    end

    // R7: the line only moves while the clock is low
    assert_line_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R2: an accepted command shows busy in the next cycle
    assert_busy_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> cmd_q.go);

    // R9: command fields are frozen while a frame runs
    assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && cmd_we) |=> (cmd_q[29:0] == $past(cmd_q[29:0])));

    // R8: busy clears only on leaving the idle gap
    assert_done_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_q.go) |-> ($past(state_q) == S_GAP));

    // R6: returned data changes only when a frame completes
    assert_rdata_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_q) |-> ($past(state_q) == S_GAP));

endmodule

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
module mdio_master_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  mdc_half = 8'd3;
    logic        cmd_we = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_rdata;
    logic        wd_we = 1'b0;
    logic [15:0] wd_wdata = '0;
    logic [15:0] rd_data;
    logic        mdc, mdio_o, mdio_oe, mdio_i;
    logic        busy;
    logic        phy_en = 1'b0, phy_bit = 1'b0, phy_read = 1'b0;
    logic [15:0] phy_rd = '0;
    logic        mdio_line;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [63:0] q_line[$];
    logic [63:0] q_oe[$];
    logic [15:0] q_rd[$];
    int          q_half[$];
    logic [15:0] last_rd = '0;

    always #2 clk = ~clk;

    assign busy      = cmd_rdata[30];
    assign mdio_line = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);
    assign mdio_i    = mdio_line;

    mdio_master uut (
        .clk(clk), .rst_n(rst_n), .mdc_half(mdc_half),
        .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
        .wd_we(wd_we), .wd_wdata(wd_wdata), .rd_data(rd_data),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic go, input logic [1:0] st,
                                       input logic [1:0] op, input logic [4:0] phy,
                                       input logic [4:0] dev, input logic [15:0] ra);
        return {1'b0, go, st, op, phy, dev, ra};
    endfunction

    function automatic logic [63:0] exp_line(input logic [1:0] st, input logic [1:0] op,
                                             input logic [4:0] phy, input logic [4:0] dev,
                                             input logic [15:0] ra, input logic [15:0] wd,
                                             input logic [15:0] rd);
        logic [1:0]  ta;
        logic [15:0] d;
        if (op[1]) begin
            ta = 2'b11;
            d  = rd;
        end else begin
            ta = 2'b10;
            d  = (st == 2'b00 && op == 2'b00) ? ra : wd;
        end
        return {32'hFFFF_FFFF, st, op, phy, dev, ta, d};
    endfunction

    // driver: pushes expectations, then issues the command
    task automatic run_frame(input logic [1:0] st, input logic [1:0] op,
                             input logic [4:0] phy, input logic [4:0] dev,
                             input logic [15:0] ra, input logic [15:0] wd,
                             input logic [15:0] prd, input bit intrude);
        logic [31:0] word;
        @(negedge clk);
        wd_we = 1'b1; wd_wdata = wd;
        @(negedge clk);
        wd_we = 1'b0;
        phy_rd = prd;
        phy_read = op[1];
        q_line.push_back(exp_line(st, op, phy, dev, ra, wd, prd));
        q_oe.push_back(op[1] ? {{46{1'b1}}, 18'h0} : {64{1'b1}});
        if (op[1]) last_rd = prd;
        q_rd.push_back(last_rd);
        q_half.push_back(int'(mdc_half));
        word = mk(1'b1, st, op, phy, dev, ra);
        cmd_we = 1'b1; cmd_wdata = word;
        @(negedge clk);
        cmd_we = 1'b0;
        chk(cmd_rdata == word, "R2 readback with go set", {32'h0, cmd_rdata}, {32'h0, word});
        if (intrude) begin
            repeat (60) @(negedge clk);
            cmd_we = 1'b1; cmd_wdata = mk(1'b1, 2'b00, 2'b11, 5'h15, 5'h0A, 16'h5555);
            @(negedge clk);
            cmd_we = 1'b0;
            chk(cmd_rdata == word, "R9 readback unchanged", {32'h0, cmd_rdata}, {32'h0, word});
        end
        while (busy) @(negedge clk);
        if (intrude) begin
            repeat (40) @(negedge clk);
            chk(!busy && !mdc, "R9 no second frame", {62'h0, busy, mdc}, 64'h0);
        end
        repeat (4) @(negedge clk);
    endtask

    // PHY model: drives read data while MDC is low
    initial begin
        int k;
        k = 0;
        forever begin
            @(posedge mdc);
            k++;
            @(negedge mdc);
            if (phy_read && k >= 48 && k <= 63) begin
                phy_en  = 1'b1;
                phy_bit = phy_rd[63 - k];
            end else begin
                phy_en = 1'b0;
            end
            if (k >= 65) k = 0;
        end
    end

    // monitor / scoreboard
    initial begin
        int nb;
        logic [63:0] capl, capo, el, eo;
        logic [15:0] er;
        int eh;
        time t0, per;
        nb = 0; capl = '0; capo = '0; t0 = 0; per = 0;
        wait (rst_n);
        forever begin
            @(posedge mdc or negedge busy);
            #1;
            if (mdc) begin
                if (nb < 64) begin
                    capl[63 - nb] = mdio_line;
                    capo[63 - nb] = mdio_oe;
                end
                if (nb == 0) t0 = $time;
                if (nb == 1) per = $time - t0;
                nb++;
            end else if (q_line.size() == 0) begin
                chk(1'b0, "R9 unexpected frame end", 64'h1, 64'h0);
                nb = 0;
            end else begin
                el = q_line.pop_front();
                eo = q_oe.pop_front();
                er = q_rd.pop_front();
                eh = q_half.pop_front();
                chk(capl[63:32] == el[63:32], "R3 preamble", capl, el);
                chk(capl[31:18] == el[31:18], "R4 header fields", capl, el);
                if (eo[0])
                    chk(capl[17:0] == el[17:0], "R5 turnaround and payload", capl, el);
                else
                    chk(capl[17:0] == el[17:0], "R6 released turnaround and data", capl, el);
                chk(capo == eo, "R6 output enable pattern", capo, eo);
                if (eo[0])
                    chk(rd_data == er, "R10 read data kept", {48'h0, rd_data}, {48'h0, er});
                else
                    chk(rd_data == er, "R6 read data captured", {48'h0, rd_data}, {48'h0, er});
                chk(per == time'(8 * (eh + 1)), "R7 MDC period", 64'(per), 64'(8 * (eh + 1)));
                chk(nb == 65, "R8 one idle clock", 64'(nb), 64'd65);
                chk(!mdc && !mdio_oe, "R8 idle after done", {62'h0, mdc, mdio_oe}, 64'h0);
                nb = 0;
            end
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(!mdc && !mdio_oe, "R1 line idle in reset", {62'h0, mdc, mdio_oe}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_rdata == 32'h0, "R1 command clear", {32'h0, cmd_rdata}, 64'h0);
        chk(rd_data == 16'h0, "R1 read data clear", {48'h0, rd_data}, 64'h0);

        // short framing write: regad bits must not reach the line (R4)
        run_frame(2'b01, 2'b01, 5'h03, 5'h11, 16'hDEAD, 16'hA5C3, 16'h0000, 1'b0);
        // short framing read
        run_frame(2'b01, 2'b10, 5'h1F, 5'h00, 16'h0000, 16'h0000, 16'h1234, 1'b0);
        // extended address frame
        run_frame(2'b00, 2'b00, 5'h0A, 5'h1E, 16'hBEEF, 16'h0000, 16'h0000, 1'b0);
        // extended write with a slower clock
        mdc_half = 8'd5;
        run_frame(2'b00, 2'b01, 5'h15, 5'h01, 16'h0F0F, 16'hF00F, 16'h0000, 1'b0);
        mdc_half = 8'd3;
        // extended reads
        run_frame(2'b00, 2'b11, 5'h00, 5'h1F, 16'h0000, 16'h0000, 16'h8001, 1'b0);
        run_frame(2'b00, 2'b10, 5'h11, 5'h07, 16'h0000, 16'h0000, 16'h7E5A, 1'b0);
        // command issued while busy
        run_frame(2'b01, 2'b01, 5'h0C, 5'h05, 16'h0000, 16'h3C96, 16'h0000, 1'b1);

        chk(q_line.size() == 0, "R8 all frames completed", 64'(q_line.size()), 64'h0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R8 actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule